// File: doc/BRIEF.md
# Keyed Power-Down Guard

This block keeps a memory power-down control bit out of reach of stray software writes. The bit lives in a small control register. It can only be set after two fixed 32-bit key words have been written, in a set order, to a dedicated key register. Once the bit is set, the block drives a power-down request to the memory. Clearing the bit lifts the request and locks the guard again. The next power-down then needs both keys once more.

The key sequence never raises an error. A wrong word simply sends the sequence back to waiting for the first key. Writes to other addresses, and reads of any address, may fall between the two keys without disturbing the sequence.

Software reads the register file through a read port with one cycle of latency. The control register shows the power-down bit together with a read-only unlocked flag. The key register always reads as zero.

Top module: `pd_key_guard`

## Requirements
- R1: After reset, `pd_req` is 0, the guard is locked, and a read of the control register (address 0) returns 0.
- R2: Writing 0x04152637 and then 0xFAFBFCFD to the key register (address 1) unlocks the guard. The unlocked flag is bit 1 of the control register and reads 1 from then on.
- R3: Writes to addresses other than the key register, and reads of any address, placed between the two key writes leave the sequence intact.
- R4: Any other value written to the key register while it waits for the second key sends it back to waiting for the first key. Writing the first key again at that point counts as a fresh first key. A wrong value never raises an error, and a wrong value while locked leaves the guard locked.
- R5: Writing the second key while the guard waits for the first key does not unlock the guard.
- R6: While the guard is locked, a write to the control register leaves the power-down bit (bit 0) and `pd_req` unchanged.
- R7: While the guard is unlocked, writing 1 to bit 0 of the control register sets `pd_req` from the next cycle on, and bit 0 reads back as 1.
- R8: Writing 0 to bit 0 while it holds 1 clears `pd_req` and locks the guard. A following write of 1 is then ignored until both keys have been written again. Writing 0 while the bit is already 0 does not lock the guard.
- R9: The key register reads as 0. Bit 1 of the control register cannot be changed by a write to that register.
- R10: A read strobed in one cycle returns `rd_valid` = 1 and its data in the next cycle. Addresses other than 0 and 1 read as 0.
- R11: Key-register writes of any value while the guard is unlocked leave it unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read data |
| pd_req | output | 1 | Power-down request to the memory |

## Verification
The bench goes after the ordering corners of the key sequence:
- The second key sent alone. A design that ignored order would unlock here.
- A garbage word between the keys. A design that never reset the sequence would unlock after it.
- The first key written twice. A design that treated the repeat as wrong would stay locked.
- Unrelated traffic between the keys. A design that reset on any bus activity would never unlock.

It also checks that clearing the power-down bit locks the guard, so a second set without keys must fail. A design without auto-relock would let that second set through. Finally, it checks that writing 0 to an already-clear bit keeps the guard open; a design that relocked on any zero write would break here.

// File: rtl/pdk_pkg.sv
package pdk_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;
endpackage

// File: rtl/pdk_key_seq.sv
module pdk_key_seq
   import pdk_pkg::*;
#(
   parameter int          DATA_W           = 32,
   parameter logic [31:0] KEY_FIRST        = 32'h0415_2637,
   parameter logic [31:0] KEY_SECOND       = 32'hFAFB_FCFD,
   parameter bit          RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   input  logic              relock,
   output logic              unlocked
);
   localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

   key_state_e state_q, state_d;
   logic       repeat_first;

   generate
      if (RESTART_ON_FIRST) begin : g_restart
         assign repeat_first = (key_data == K1);
      end else begin : g_strict
         assign repeat_first = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (relock) begin
         state_d = KS_LOCKED;
      end else if (key_wr) begin
         case (state_q)
            KS_LOCKED: state_d = (key_data == K1) ? KS_HALF : KS_LOCKED;
            KS_HALF: begin
               if (key_data == K2)   state_d = KS_OPEN;
               else if (repeat_first) state_d = KS_HALF;
               else                   state_d = KS_LOCKED;
            end
            KS_OPEN:   state_d = KS_OPEN;
            default:   state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KS_OPEN);

   // R2
   open_needs_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_data == K2 && state_q == KS_HALF));

   // R11
   open_holds_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && key_wr && !relock) |=> unlocked);
endmodule

// File: rtl/pdk_pd_bit.sv
module pdk_pd_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic pd_wdata,
   input  logic unlocked,
   output logic pd_q,
   output logic relock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pd_q <= 1'b0;
      else if (ctrl_wr && unlocked) pd_q <= pd_wdata;
   end

   assign relock = ctrl_wr && pd_q && !pd_wdata;

   // R6
   locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !unlocked) |=> $stable(pd_q));
endmodule

// File: rtl/pdk_rd_port.sv
module pdk_rd_port #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int CTRL_ADDR = 0,
   parameter int KEY_ADDR  = 1,
   parameter int PD_BIT    = 0,
   parameter int ST_BIT    = 1,
   parameter int RD_LAT    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              pd_q,
   input  logic              unlocked,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      if (rd_addr == A_CTRL) begin
         word[PD_BIT] = pd_q;
         word[ST_BIT] = unlocked;
      end
   end

   generate
      if (RD_LAT == 0) begin : g_comb
         assign rd_valid = rd_en;
         assign rd_data  = rd_en ? word : '0;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_valid <= 1'b0;
               rd_data  <= '0;
            end else begin
               rd_valid <= rd_en;
               rd_data  <= rd_en ? word : '0;
            end
         end

         // R10
         rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> rd_valid);

         // R9
         key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == A_KEY) |=> (rd_data == '0));
      end
   endgenerate
endmodule

// File: rtl/pd_key_guard.sv
module pd_key_guard
   import pdk_pkg::*;
#(
   parameter int          ADDR_W           = 4,
   parameter int          DATA_W           = 32,
   parameter int          CTRL_ADDR        = 0,
   parameter int          KEY_ADDR         = 1,
   parameter int          PD_BIT           = 0,
   parameter int          ST_BIT           = 1,
   parameter int          RD_LAT           = 1,
   parameter logic [31:0] KEY_FIRST        = 32'h0415_2637,
   parameter logic [31:0] KEY_SECOND       = 32'hFAFB_FCFD,
   parameter bit          RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              pd_req
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);

   generate
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
         $error("pd_key_guard: the two keys must differ");
      end
      if (CTRL_ADDR == KEY_ADDR) begin : g_bad_addr
         $error("pd_key_guard: control and key addresses collide");
      end
      if (PD_BIT == ST_BIT || PD_BIT >= DATA_W || ST_BIT >= DATA_W) begin : g_bad_bits
         $error("pd_key_guard: bad control bit positions");
      end
      if (DATA_W > 32 || RD_LAT > 1 || RD_LAT < 0) begin : g_bad_cfg
         $error("pd_key_guard: unsupported width or read latency");
      end
   endgenerate

   logic key_wr, ctrl_wr, unlocked, pd_q, relock;

   assign key_wr  = wr_en && (wr_addr == A_KEY);
   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   pdk_key_seq #(
      .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
      .RESTART_ON_FIRST(RESTART_ON_FIRST)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data),
      .relock(relock), .unlocked(unlocked)
   );

   pdk_pd_bit pd_i (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .pd_wdata(wr_data[PD_BIT]),
      .unlocked(unlocked), .pd_q(pd_q), .relock(relock)
   );

   pdk_rd_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .KEY_ADDR(KEY_ADDR),
      .PD_BIT(PD_BIT), .ST_BIT(ST_BIT), .RD_LAT(RD_LAT)
   ) rd_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .pd_q(pd_q), .unlocked(unlocked), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign pd_req = pd_q;

   // R7
   pd_only_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |-> unlocked);

   // R8
   clear_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_req) |-> !unlocked);

   // R6
   rise_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_req) |-> $past(unlocked && ctrl_wr));
endmodule

// File: tb/pd_key_guard_tb_top.sv
module pd_key_guard_tb_top;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam logic [31:0] K1 = 32'h0415_2637;
   localparam logic [31:0] K2 = 32'hFAFB_FCFD;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic              pd_req;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   // bench view of the guard, updated from the requirements
   int m_seq = 0;   // 0 waiting first key, 1 waiting second key, 2 unlocked
   bit m_pd  = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   pd_key_guard dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .pd_req(pd_req)
   );

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected <= 20000", cycles);
         finish_run();
      end
   end

   task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected rd_valid", 32'd1, 32'd0);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
      logic [DATA_W-1:0] v = '0;
      if (a == 0) begin
         v[0] = m_pd;
         v[1] = (m_seq == 2);
      end
      return v;
   endfunction

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a == 1) begin
         case (m_seq)
            0: m_seq = (d == K1) ? 1 : 0;
            1: m_seq = (d == K2) ? 2 : ((d == K1) ? 1 : 0);
            default: m_seq = 2;
         endcase
      end else if (a == 0) begin
         if (m_seq == 2) begin
            if (m_pd && !d[0]) m_seq = 0;
            m_pd = d[0];
         end
      end
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      exp_q.push_back(exp_read(a));
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      @(negedge clk);
      chk("R10 queue drained", 32'(exp_q.size()), 32'd0);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_seq = 0; m_pd = 1'b0;
   endtask

   initial begin
      apply_reset();
      // R1 reset state
      chk("R1 pd_req after reset", 32'(pd_req), 32'd0);
      do_read(0, "R1 ctrl after reset");
      // R6 locked write ignored
      do_write(0, 32'h1);
      chk("R6 pd_req locked write", 32'(pd_req), 32'd0);
      do_read(0, "R6 ctrl after locked write");
      // R5 second key alone
      do_write(1, K2);
      do_read(0, "R5 second key alone");
      // R4 wrong word between keys
      do_write(1, 32'h1234_5678);
      do_write(1, K1);
      do_write(1, 32'hDEAD_BEEF);
      do_write(1, K2);
      do_read(0, "R4 wrong key resets sequence");
      // R3 unrelated traffic between keys, then R2 unlock
      do_write(1, K1);
      do_write(2, K2);
      do_read(3, "R10 unmapped address reads zero");
      do_write(0, 32'h1);
      chk("R6 pd_req write while half", 32'(pd_req), 32'd0);
      do_write(1, K2);
      do_read(0, "R2 R3 unlocked after keys with traffic");
      // R9 key reads zero, status read-only
      do_read(1, "R9 key register reads zero");
      do_write(0, 32'h0);
      do_read(0, "R9 R8 zero write on clear bit keeps unlock");
      // R11 key writes while open
      do_write(1, 32'h0BAD_0BAD);
      do_read(0, "R11 open after stray key");
      // R7 set power-down
      do_write(0, 32'h1);
      chk("R7 pd_req set", 32'(pd_req), 32'd1);
      do_read(0, "R7 ctrl reads pd and unlock");
      // R8 clear relocks
      do_write(0, 32'h0);
      chk("R8 pd_req cleared", 32'(pd_req), 32'd0);
      do_read(0, "R8 relocked after clear");
      do_write(0, 32'h1);
      chk("R8 set ignored after relock", 32'(pd_req), 32'd0);
      // R4 repeated first key counts as new first key
      do_write(1, K1);
      do_write(1, K1);
      do_write(1, K2);
      do_read(0, "R4 repeated first key");
      do_write(0, 32'h3);
      chk("R7 pd_req set again", 32'(pd_req), 32'd1);
      drain();
      // R1 reset while powered down
      apply_reset();
      chk("R1 pd_req after second reset", 32'(pd_req), 32'd0);
      chk("R10 rd_valid idle", 32'(rd_valid), 32'd0);
      do_read(0, "R1 locked after second reset");
      drain();
      finish_run();
   end
endmodule